// File: doc/BRIEF.md
# Dual-Counter Partial Re-encryption Controller

This block sits between a line buffer and a counter-mode pad generator for one line of a non-volatile memory whose writes are expensive per flipped bit. It stores a single line counter and one modified flag per word. Each write moves the counter forward by one. Inside an epoch, only the words that have changed since the epoch began are encrypted again with a pad built from the current counter. The other words keep the ciphertext they were given at the epoch start. That older pad is built from the epoch-aligned value of the counter, which is the counter with its low bits masked, so no second counter is stored.

A command port takes either a write or a read. A write carries the full plaintext line and a per-word dirty mask. The result is the new ciphertext together with a per-word write mask, which tells the memory which words to store. A read carries the stored ciphertext. The result is the plaintext, in which each word has been unmasked with the leading-counter pad or the trailing-counter pad according to that word's modified flag. Pads come from an external function of line address and counter value, reached through a request port with a valid/ready handshake and a response port with a valid strobe. A write that would carry the counter past its largest value is refused. The refusal is reported through a sticky error flag, so no pad is ever used twice.

Top module: `dual_ctr_crypt`

## Requirements
- R1: After reset the line counter is 0, every modified flag is clear, `wrap_err` is 0, `cmd_ready` is 1, and `res_valid` and `pad_req_valid` are 0. A first read therefore asks for exactly one pad, with counter 0.
- R2: Every accepted write that is not refused sends exactly one pad request, whose counter is the previous line counter plus one. That value becomes the new line counter.
- R3: When the new counter of a write is a multiple of EPOCH (EPOCH is a power of two), `res_wmask` is all ones. Every word of `res_data` is then plaintext XOR pad(address, new counter), and all modified flags are cleared.
- R4: On any other write, the modified flags become the old flags OR `cmd_dirty`. `res_wmask` equals those flags, and each word whose mask bit is set is plaintext XOR pad(address, new counter). Bit w of every mask refers to the word at bits [w*WORD_W +: WORD_W].
- R5: Each word whose `res_wmask` bit is 0 is driven as zero in `res_data` and must not be stored. The ciphertext already in memory for that word stays decryptable by later reads.
- R6: A read whose counter differs from its epoch-aligned value (the counter with its low log2(EPOCH) bits cleared) requests two pads, the leading counter first and then the aligned one. Each word is decrypted with the leading pad if its modified flag is set and with the trailing pad otherwise. `res_wmask` is 0 on reads.
- R7: A read whose counter is already epoch-aligned requests only one pad.
- R8: A write while the counter holds its largest value (all ones) sends no pad request. It returns `res_err`=1 with `res_wmask`=0, leaves the counter and the modified flags unchanged, and sets `wrap_err`, which stays set until reset.
- R9: While `pad_req_valid` is high and `pad_req_ready` is low, the request stays valid and its address and counter do not change.
- R10: A command is accepted only when `cmd_ready` is high. Each accepted command yields exactly one `res_valid` pulse, and `cmd_ready` stays low until that pulse has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command accepted this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Line address passed on to the pad function |
| cmd_dirty | input | LINE_W/WORD_W | Words changed by this write |
| cmd_data | input | LINE_W | Plaintext line (write) or stored ciphertext (read) |
| pad_req_valid | output | 1 | Pad request present |
| pad_req_ready | input | 1 | Pad function takes the request |
| pad_req_addr | output | ADDR_W | Address for the pad |
| pad_req_ctr | output | CTR_W | Counter value for the pad |
| pad_rsp_valid | input | 1 | Pad returned |
| pad_rsp_data | input | LINE_W | Pad bits |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | LINE_W | Ciphertext (write) or plaintext (read) |
| res_wmask | output | LINE_W/WORD_W | Words the memory must store |
| res_err | output | 1 | Write refused because the counter would wrap |
| wrap_err | output | 1 | Sticky wrap-refusal flag |

## Verification
On every cycle, the assertions check that pad requests are held steady while stalled, that an epoch-start write rewrites the whole line, that every dirty word lands in the write mask, and that the counter advances by one per accepted write. They also check that a refused write stores nothing, that the error flag is sticky, and that a busy controller gives its result before it accepts another command. Only the bench scenarios can show whether the ciphertext words match pad(address, counter) for the right counter. The same holds for whether words that are not rewritten still decrypt correctly later through the trailing pad, and whether reads fetch one pad or two in the right order. The bench drives a write sequence through a whole epoch, with an empty dirty mask in the middle, and then on up to the counter limit.

// File: rtl/dual_ctr_crypt.sv
module dual_ctr_crypt #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 16,
  parameter int EPOCH  = 32,
  parameter int CTR_W  = 28,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LINE_W/WORD_W-1:0] cmd_dirty,
  input  logic [LINE_W-1:0] cmd_data,
  output logic              pad_req_valid,
  input  logic              pad_req_ready,
  output logic [ADDR_W-1:0] pad_req_addr,
  output logic [CTR_W-1:0]  pad_req_ctr,
  input  logic              pad_rsp_valid,
  input  logic [LINE_W-1:0] pad_rsp_data,
  output logic              res_valid,
  output logic [LINE_W-1:0] res_data,
  output logic [LINE_W/WORD_W-1:0] res_wmask,
  output logic              res_err,
  output logic              wrap_err
);
  localparam int NW = LINE_W / WORD_W;
  localparam logic [CTR_W-1:0] EMASK = CTR_W'(EPOCH - 1);
  localparam logic [CTR_W-1:0] TMASK = ~EMASK;
  localparam logic [CTR_W-1:0] CMAX  = '1;

  typedef enum logic [2:0] {S_IDLE, S_REQA, S_WAITA, S_REQB, S_WAITB, S_DONE} st_t;

  st_t               st;
  logic [CTR_W-1:0]  ctr, op_ctr;
  logic [NW-1:0]     mod, op_mod;
  logic              op_ep, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [LINE_W-1:0] op_data, pad_a;

  logic [CTR_W-1:0]  ctr_inc;
  logic              ep_next, single_pad;
  logic [NW-1:0]     mod_merge, op_mask;
  logic [LINE_W-1:0] lead_pad, wr_line, rd_line;

  assign ctr_inc    = ctr + 1'b1;
  assign ep_next    = (ctr_inc & EMASK) == '0;
  assign mod_merge  = mod | cmd_dirty;
  assign op_mask    = op_ep ? '1 : op_mod;
  assign single_pad = op_ctr == (op_ctr & TMASK);
  assign lead_pad   = (st == S_WAITB) ? pad_a : pad_rsp_data;

  assign cmd_ready     = st == S_IDLE;
  assign res_valid     = st == S_DONE;
  assign pad_req_valid = (st == S_REQA) || (st == S_REQB);
  assign pad_req_addr  = op_addr;
  assign pad_req_ctr   = (st == S_REQB) ? (op_ctr & TMASK) : op_ctr;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign wr_line[w*WORD_W +: WORD_W] = op_mask[w]
        ? op_data[w*WORD_W +: WORD_W] ^ pad_rsp_data[w*WORD_W +: WORD_W]
        : '0;
    assign rd_line[w*WORD_W +: WORD_W] = op_data[w*WORD_W +: WORD_W] ^
        (mod[w] ? lead_pad[w*WORD_W +: WORD_W] : pad_rsp_data[w*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ctr       <= '0;
      mod       <= '0;
      op_ctr    <= '0;
      op_mod    <= '0;
      op_ep     <= 1'b0;
      op_wr     <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      pad_a     <= '0;
      res_data  <= '0;
      res_wmask <= '0;
      res_err   <= 1'b0;
      wrap_err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_wr   <= cmd_write;
          op_addr <= cmd_addr;
          op_data <= cmd_data;
          op_ctr  <= cmd_write ? ctr_inc : ctr;
          op_ep   <= ep_next;
          op_mod  <= ep_next ? '0 : mod_merge;
          if (cmd_write && ctr == CMAX) begin
            res_err   <= 1'b1;
            wrap_err  <= 1'b1;
            res_wmask <= '0;
            res_data  <= '0;
            st        <= S_DONE;
          end else begin
            res_err <= 1'b0;
            st      <= S_REQA;
          end
        end
        S_REQA: if (pad_req_ready) st <= S_WAITA;
        S_WAITA: if (pad_rsp_valid) begin
          if (op_wr) begin
            res_data  <= wr_line;
            res_wmask <= op_mask;
            ctr       <= op_ctr;
            mod       <= op_mod;
            st        <= S_DONE;
          end else if (single_pad) begin
            res_data  <= rd_line;
            res_wmask <= '0;
            st        <= S_DONE;
          end else begin
            pad_a <= pad_rsp_data;
            st    <= S_REQB;
          end
        end
        S_REQB: if (pad_req_ready) st <= S_WAITB;
        S_WAITB: if (pad_rsp_valid) begin
          res_data  <= rd_line;
          res_wmask <= '0;
          st        <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_ctr_crypt_chk.sv
module dual_ctr_crypt_chk #(
  parameter int NW     = 32,
  parameter int CTR_W  = 28,
  parameter int ADDR_W = 32,
  parameter int EPOCH  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [NW-1:0]     cmd_dirty,
  input logic              pad_req_valid,
  input logic              pad_req_ready,
  input logic [ADDR_W-1:0] pad_req_addr,
  input logic [CTR_W-1:0]  pad_req_ctr,
  input logic              res_valid,
  input logic [NW-1:0]     res_wmask,
  input logic              res_err,
  input logic              wrap_err,
  input logic [CTR_W-1:0]  ctr
);
  localparam logic [CTR_W-1:0] EMASK = CTR_W'(EPOCH - 1);

  logic             c_wr;
  logic [NW-1:0]    c_dirty;
  logic [CTR_W-1:0] c_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wr    <= 1'b0;
      c_dirty <= '0;
      c_ctr   <= '0;
    end else if (cmd_valid && cmd_ready) begin
      c_wr    <= cmd_write;
      c_dirty <= cmd_dirty;
      c_ctr   <= ctr;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pad_req_valid && !pad_req_ready |=> pad_req_valid && $stable(pad_req_ctr) && $stable(pad_req_addr));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_err |=> wrap_err);

  assert_err_nomask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_wmask == '0 && wrap_err);

  assert_epoch_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && c_wr && !res_err && (ctr & EMASK) == '0 |-> &res_wmask);

  assert_dirty_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && c_wr && !res_err |-> (res_wmask & c_dirty) == c_dirty);

  assert_ctr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && c_wr && !res_err |-> ctr == CTR_W'(c_ctr + 1'b1));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);

  assert_read_nomask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !c_wr |-> res_wmask == '0);
endmodule

bind dual_ctr_crypt dual_ctr_crypt_chk #(
  .NW(NW), .CTR_W(CTR_W), .ADDR_W(ADDR_W), .EPOCH(EPOCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_dirty(cmd_dirty), .pad_req_valid(pad_req_valid),
  .pad_req_ready(pad_req_ready), .pad_req_addr(pad_req_addr), .pad_req_ctr(pad_req_ctr),
  .res_valid(res_valid), .res_wmask(res_wmask), .res_err(res_err),
  .wrap_err(wrap_err), .ctr(ctr)
);

// File: tb/sim_dual_ctr_crypt.sv
module sim_dual_ctr_crypt;
  localparam int LW = 512, WW = 16, NW = LW / WW;
  localparam int EPOCH = 4, CTR_W = 5, ADDR_W = 32;
  localparam logic [ADDR_W-1:0] ADDR = 32'h0004_1C80;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [ADDR_W-1:0] cmd_addr = ADDR;
  logic [NW-1:0] cmd_dirty = '0;
  logic [LW-1:0] cmd_data = '0;
  logic pad_req_ready = 0, pad_rsp_valid = 0;
  logic [LW-1:0] pad_rsp_data = '0;
  logic cmd_ready, pad_req_valid, res_valid, res_err, wrap_err;
  logic [ADDR_W-1:0] pad_req_addr;
  logic [CTR_W-1:0] pad_req_ctr;
  logic [LW-1:0] res_data;
  logic [NW-1:0] res_wmask;

  always #10 clk = ~clk;

  dual_ctr_crypt #(.LINE_W(LW), .WORD_W(WW), .EPOCH(EPOCH), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_dirty(cmd_dirty), .cmd_data(cmd_data),
    .pad_req_valid(pad_req_valid), .pad_req_ready(pad_req_ready), .pad_req_addr(pad_req_addr),
    .pad_req_ctr(pad_req_ctr), .pad_rsp_valid(pad_rsp_valid), .pad_rsp_data(pad_rsp_data),
    .res_valid(res_valid), .res_data(res_data), .res_wmask(res_wmask),
    .res_err(res_err), .wrap_err(wrap_err));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pad_fn(input logic [ADDR_W-1:0] a, input logic [CTR_W-1:0] c);
    logic [LW-1:0] p;
    for (int k = 0; k < LW / 32; k++) begin
      logic [31:0] x;
      x = (32'(c) * 32'h9E37_79B1) ^ (a * 32'h85EB_CA77) ^ (32'(k) * 32'hC2B2_AE3D) ^ 32'h5A17_03C9;
      x = x ^ (x >> 13);
      x = x * 32'h27D4_EB2F;
      x = x ^ (x >> 16);
      p[k*32 +: 32] = x;
    end
    return p;
  endfunction

  // pad responder with variable stall
  int req_n = 0, req_total = 0, stall_cnt = 0;
  logic [CTR_W-1:0] req_ctr [4];
  logic [CTR_W-1:0] cap_ctr;
  logic [ADDR_W-1:0] cap_addr;

  initial begin
    forever begin
      @(negedge clk);
      pad_rsp_valid = 0;
      if (pad_req_ready) begin
        pad_req_ready = 0;
        pad_rsp_valid = 1;
        pad_rsp_data  = pad_fn(cap_addr, cap_ctr);
        if (req_n < 4) req_ctr[req_n] = cap_ctr;
        req_n++;
        req_total++;
      end else if (pad_req_valid) begin
        if (stall_cnt == 0) begin
          cap_ctr  = pad_req_ctr;
          cap_addr = pad_req_addr;
        end else begin
          chk(pad_req_ctr == cap_ctr && pad_req_addr == cap_addr, "R9 stalled request held",
              LW'(pad_req_ctr), LW'(cap_ctr));
        end
        if (stall_cnt >= req_total % 3) begin
          pad_req_ready = 1;
          stall_cnt = 0;
        end else stall_cnt++;
      end
    end
  end

  // reference line model
  logic [LW-1:0] m_plain, m_mem;
  logic [NW-1:0] m_mod = '0;
  logic [CTR_W-1:0] m_ctr = '0;

  task automatic issue(input bit wr, input logic [NW-1:0] dirty, input logic [LW-1:0] data);
    @(negedge clk);
    chk(cmd_ready, "R10 ready when idle", LW'(cmd_ready), 1);
    cmd_valid = 1; cmd_write = wr; cmd_dirty = dirty; cmd_data = data; req_n = 0;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R10 busy after accept", LW'(cmd_ready), 0);
    while (!res_valid) @(negedge clk);
  endtask

  task automatic do_write(input logic [NW-1:0] dirty, input int seed, input string mreq);
    logic [LW-1:0] pt, exp, p;
    logic [NW-1:0] emask;
    logic [CTR_W-1:0] nc;
    pt = m_plain;
    for (int w = 0; w < NW; w++)
      if (dirty[w]) pt[w*WW +: WW] = 16'(seed * 40503 + w * 7919 + 1);
    nc = m_ctr + 1'b1;
    if ((nc & CTR_W'(EPOCH - 1)) == '0) begin emask = '1; m_mod = '0; end
    else begin m_mod = m_mod | dirty; emask = m_mod; end
    p = pad_fn(ADDR, nc);
    exp = '0;
    for (int w = 0; w < NW; w++)
      if (emask[w]) exp[w*WW +: WW] = pt[w*WW +: WW] ^ p[w*WW +: WW];
    issue(1, dirty, pt);
    chk(req_n == 1 && req_ctr[0] == nc, "R2 one pad request at counter+1", LW'(req_ctr[0]), LW'(nc));
    chk(res_wmask == emask, mreq, LW'(res_wmask), LW'(emask));
    chk(res_data == exp, "R4/R5 ciphertext words, unmasked words zero", res_data, exp);
    chk(!res_err, "R8 no error on normal write", LW'(res_err), 0);
    for (int w = 0; w < NW; w++)
      if (emask[w]) m_mem[w*WW +: WW] = res_data[w*WW +: WW];
    m_plain = pt;
    m_ctr = nc;
  endtask

  task automatic do_read(input string req);
    logic [CTR_W-1:0] tr;
    int en;
    tr = m_ctr & ~CTR_W'(EPOCH - 1);
    en = (tr == m_ctr) ? 1 : 2;
    issue(0, '0, m_mem);
    chk(req_n == en, "R7 pad request count", LW'(req_n), LW'(en));
    chk(req_ctr[0] == m_ctr, "R6 first pad is leading counter", LW'(req_ctr[0]), LW'(m_ctr));
    if (en == 2)
      chk(req_ctr[1] == tr, "R6 second pad is trailing counter", LW'(req_ctr[1]), LW'(tr));
    chk(res_data == m_plain, req, res_data, m_plain);
    chk(res_wmask == '0, "R6 no write mask on read", LW'(res_wmask), 0);
  endtask

  task automatic t_reset;
    chk(cmd_ready && !res_valid && !pad_req_valid && !wrap_err, "R1 idle outputs after reset",
        LW'({cmd_ready, res_valid, pad_req_valid, wrap_err}), LW'(4'b1000));
    do_read("R1 read at counter 0 decrypts");
    chk(req_ctr[0] == '0, "R1 counter zero after reset", LW'(req_ctr[0]), 0);
  endtask

  task automatic t_epoch;
    logic [NW-1:0] d;
    d = '0; d[0] = 1; d[7] = 1;
    do_write(d, 1, "R4 mask after first write");
    d = '0; d[7] = 1;
    do_write(d, 2, "R4 mask keeps earlier words");
    do_read("R6 mixed-pad read, R5 untouched words");
    d = '0; d[2] = 1; d[4] = 1;
    do_write(d, 3, "R4 mask accumulates");
    d = '0; d[4] = 1;
    do_write(d, 4, "R3 epoch start rewrites all");
    do_read("R7 aligned read decrypts");
  endtask

  task automatic t_inside;
    logic [NW-1:0] d;
    d = '0; d[1] = 1;
    do_write(d, 5, "R4 first write after epoch start");
    do_write('0, 6, "R4 empty dirty keeps flags");
    do_read("R6 two-pad read decrypts");
  endtask

  task automatic t_wrap;
    while (m_ctr != '1) begin
      logic [NW-1:0] d;
      d = NW'(32'h1 << (m_ctr % NW)) | NW'(32'h100 << (m_ctr % 7));
      do_write(d, 10 + int'(m_ctr), ((m_ctr + 1'b1) % EPOCH == 0) ? "R3 epoch start" : "R4 inside epoch");
    end
    issue(1, '1, ~m_plain);
    chk(res_err && wrap_err, "R8 wrap write refused", LW'({res_err, wrap_err}), LW'(2'b11));
    chk(req_n == 0, "R8 no pad on wrap", LW'(req_n), 0);
    chk(res_wmask == '0, "R8 nothing stored on wrap", LW'(res_wmask), 0);
    do_read("R8 counter and flags unchanged after refusal");
    chk(wrap_err, "R8 error flag sticky", LW'(wrap_err), 1);
  endtask

  initial begin
    m_plain = '0;
    for (int w = 0; w < NW; w++) m_plain[w*WW +: WW] = 16'(w * 257 + 3);
    m_mem = m_plain ^ pad_fn(ADDR, '0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_epoch;
    t_inside;
    t_wrap;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule